// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a chain of identical 4-bit synchronous up-counter stages that together form one wide binary counter. Each stage updates all of its state bits together on the rising clock edge. A stage can be preset from a parallel data word, and its count can be held by either of two enables. A carry output is high only when the stage holds its largest value and the stage's carry-chain enable is high. Each stage drives the carry-chain enable of the next, more significant stage with that carry. The parallel-count enable, the load strobe, the clear and the clock are shared by all stages. Because of this wiring the whole chain counts as one synchronous binary counter and needs no extra gating.

Priority is fixed. The asynchronous clear wins over everything. The synchronous load comes next and overrides both enables. Counting happens only when both enables are high. In every other case the stages hold their value. The top module sets the number of stages and the width of a stage by parameter.

Top module: `presetCounterChain`

## Requirements
- R1: While clearN is low, countQ is 0. This takes effect at once, without waiting for a clock edge, and holds whatever clk, loadN or the enables do.
- R2: If loadN is low at a rising edge, countQ takes loadVal at that edge whatever cntEnP and cntEnT are. loadVal bit 0 goes to countQ bit 0, the least significant bit.
- R3: If loadN, cntEnP and cntEnT are all high at a rising edge, countQ increments by one. It wraps from all ones to 0, with no saturation.
- R4: If loadN is high and cntEnP or cntEnT is low at a rising edge, countQ keeps its value.
- R5: carryOut is combinational and equals cntEnT AND (countQ is all ones). cntEnP has no effect on it.
- R6: Changes on loadN, cntEnP or cntEnT between clock edges leave countQ unchanged until the next rising edge.
- R7: A single stage reproduces this sequence: clear to 0, load 12, count 13, 14, 15, 0, 1, 2, then hold once the enables drop. Its carry is high only in state 15.
- R8: The chain counts through every state of the full width in binary order. Each stage's carry feeds the next stage's carry-chain enable, and carryOut is high only at the all-ones state.
- R9: If one stage's carry-chain enable is held low, that stage and every more significant stage freeze. Less significant stages keep counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clearN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| cntEnP | input | 1 | Parallel count enable, shared by all stages |
| cntEnT | input | 1 | Carry-chain enable into the least significant stage |
| loadVal | input | STAGES*STAGE_BITS | Preset value; bit 0 is the LSB |
| countQ | output | STAGES*STAGE_BITS | Concatenated count; bit 0 is the LSB |
| carryOut | output | 1 | Carry from the most significant stage |

## Verification
The bound checker looks at every clock edge. It checks that a load lands the data, that counting adds one modulo the full width, that either low enable holds the count, that clear keeps the count at zero and that carryOut follows the carry-chain enable and the all-ones state. Some behaviours only the bench scenarios can show. These are the immediate effect of clear between edges, the immunity to control glitches between edges, the single-stage preset-count-inhibit sequence and the freeze of the upper stages when one stage's carry-chain enable is cut. Those scenarios run on a second, hand-wired chain with a mask on each stage's enable. The full-width sweep compares every state of the default chain with an arithmetic reference.

// File: rtl/cntChainPkg.sv
package cntChainPkg;
  typedef struct packed {
    logic doLoad;
    logic doInc;
  } ctrlStrobes_t;
endpackage

// File: rtl/cntCtrl.sv
module cntCtrl
  import cntChainPkg::*;
(
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.doLoad = !loadN;
    strobes.doInc  = loadN && enP && enT;
  end
endmodule

// File: rtl/cntDatapath.sv
module cntDatapath
  import cntChainPkg::*;
#(
  parameter int BITS = 4
) (
  input  logic            clk,
  input  logic            clearN,
  input  ctrlStrobes_t    strobes,
  input  logic [BITS-1:0] dIn,
  output logic [BITS-1:0] q,
  output logic            atMax
);
  localparam logic [BITS-1:0] ONE = BITS'(1);

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN)               q <= '0;
    else if (strobes.doLoad)   q <= dIn;
    else if (strobes.doInc)    q <= q + ONE;
  end

  assign atMax = &q;
endmodule

// File: rtl/counterStage.sv
module counterStage
  import cntChainPkg::*;
#(
  parameter int BITS = 4
) (
  input  logic            clk,
  input  logic            clearN,
  input  logic            loadN,
  input  logic            enP,
  input  logic            enT,
  input  logic [BITS-1:0] dIn,
  output logic [BITS-1:0] q,
  output logic            rco
);
  ctrlStrobes_t strobes;
  logic         atMax;

  cntCtrl ctrl_i (
    .loadN  (loadN),
    .enP    (enP),
    .enT    (enT),
    .strobes(strobes)
  );

  cntDatapath #(.BITS(BITS)) dp_i (
    .clk    (clk),
    .clearN (clearN),
    .strobes(strobes),
    .dIn    (dIn),
    .q      (q),
    .atMax  (atMax)
  );

  assign rco = enT && atMax;
endmodule

// File: rtl/presetCounterChain.sv
module presetCounterChain #(
  parameter int STAGES     = 3,
  parameter int STAGE_BITS = 4
) (
  input  logic                         clk,
  input  logic                         clearN,
  input  logic                         loadN,
  input  logic                         cntEnP,
  input  logic                         cntEnT,
  input  logic [STAGES*STAGE_BITS-1:0] loadVal,
  output logic [STAGES*STAGE_BITS-1:0] countQ,
  output logic                         carryOut
);
  localparam int TOTAL_W = STAGES * STAGE_BITS;

  logic [STAGES:0] carryLink;
  assign carryLink[0] = cntEnT;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    counterStage #(.BITS(STAGE_BITS)) stage_i (
      .clk   (clk),
      .clearN(clearN),
      .loadN (loadN),
      .enP   (cntEnP),
      .enT   (carryLink[k]),
      .dIn   (loadVal[k*STAGE_BITS +: STAGE_BITS]),
      .q     (countQ[k*STAGE_BITS +: STAGE_BITS]),
      .rco   (carryLink[k+1])
    );
  end

  assign carryOut = carryLink[STAGES];
endmodule

// File: rtl/counterChainChecker.sv
module counterChainChecker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         clearN,
  input logic         loadN,
  input logic         cntEnP,
  input logic         cntEnT,
  input logic [W-1:0] loadVal,
  input logic [W-1:0] countQ,
  input logic         carryOut
);
  localparam logic [W-1:0] ONE = W'(1);

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clearN |-> countQ == '0); // R1

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |=> countQ == $past(loadVal)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && cntEnP && cntEnT) |=> countQ == $past(countQ) + ONE); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && !(cntEnP && cntEnT)) |=> $stable(countQ)); // R4

  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clearN)
    carryOut == (cntEnT && (countQ == '1))); // R5
endmodule

bind presetCounterChain counterChainChecker #(.W(TOTAL_W)) chk_i (
  .clk     (clk),
  .clearN  (clearN),
  .loadN   (loadN),
  .cntEnP  (cntEnP),
  .cntEnT  (cntEnT),
  .loadVal (loadVal),
  .countQ  (countQ),
  .carryOut(carryOut)
);

// File: tb/presetCounterChain_tb_top.sv
`timescale 1ns/1ps
module presetCounterChain_tb_top;
  localparam int STAGES = 3;
  localparam int SB     = 4;
  localparam int W      = STAGES * SB;
  localparam int FULL   = 1 << W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         clearN = 1'b1;
  logic         loadN  = 1'b1;
  logic         cntEnP = 1'b0;
  logic         cntEnT = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] countQ;
  logic         carryOut;

  presetCounterChain #(.STAGES(STAGES), .STAGE_BITS(SB)) dut_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .cntEnP(cntEnP),
    .cntEnT(cntEnT), .loadVal(loadVal), .countQ(countQ), .carryOut(carryOut)
  );

  // Hand-wired chain with a mask on each stage's carry-chain enable
  logic          mLoadN = 1'b1;
  logic          mEnP   = 1'b0;
  logic          mEnT   = 1'b0;
  logic [2:0]    mMask  = 3'b111;
  logic [SB-1:0] mD [3];
  logic [SB-1:0] mQ [3];
  logic [2:0]    mRco;
  logic [2:0]    mEnt;

  for (genvar k = 0; k < 3; k++) begin : g_m
    if (k == 0) begin : g_first
      assign mEnt[k] = mEnT & mMask[k];
    end else begin : g_next
      assign mEnt[k] = mRco[k-1] & mMask[k];
    end
    counterStage #(.BITS(SB)) st_i (
      .clk(clk), .clearN(clearN), .loadN(mLoadN), .enP(mEnP), .enT(mEnt[k]),
      .dIn(mD[k]), .q(mQ[k]), .rco(mRco[k])
    );
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mD[0] = '0; mD[1] = '0; mD[2] = '0;
    // R1: clear before first edge, effective immediately
    #1 clearN = 1'b0;
    #0.5;
    chk("R1 reset", int'(countQ), 0);
    step();
    chk("R1 held through edge", int'(countQ), 0);
    clearN = 1'b1;

    // R7: single-stage reference sequence on stage 0 of the masked chain
    mD[0] = 4'd12; mEnP = 1'b1; mEnT = 1'b1; mLoadN = 1'b0;
    step();
    chk("R7 preset", int'(mQ[0]), 12);
    chk("R7 rco at preset", int'(mRco[0]), 0);
    mLoadN = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      step();
      chk("R7 count", int'(mQ[0]), (12 + i) % 16);
      chk("R7 rco", int'(mRco[0]), ((12 + i) % 16 == 15) ? 1 : 0);
    end
    mEnP = 1'b0;
    step();
    chk("R7 inhibit", int'(mQ[0]), 2);
    mEnT = 1'b0;
    step();
    chk("R7 inhibit both", int'(mQ[0]), 2);
    chk("R7 rco inhibit", int'(mRco[0]), 0);

    // R8 / R3: full-width sweep with wrap
    loadVal = '0; loadN = 1'b0;
    step();
    chk("R2 load zero", int'(countQ), 0);
    loadN = 1'b1; cntEnP = 1'b1; cntEnT = 1'b1;
    for (int i = 1; i <= FULL + 1; i++) begin
      step();
      chk("R8 sweep count", int'(countQ), i % FULL);
      chk("R8 carry", int'(carryOut), ((i % FULL) == FULL - 1) ? 1 : 0);
    end
    chk("R3 wrapped past all ones", int'(countQ), 1);

    // R2: load overrides every enable combination
    for (int c = 0; c < 4; c++) begin
      cntEnP = c[1]; cntEnT = c[0];
      loadVal = W'((c * 1234 + 567) % FULL);
      loadN = 1'b0;
      step();
      chk("R2 load under enables", int'(countQ), (c * 1234 + 567) % FULL);
    end

    // R5 / R4: carry gating and hold
    loadVal = '1; loadN = 1'b0;
    step();
    loadN = 1'b1; cntEnP = 1'b0; cntEnT = 1'b1;
    #0.5;
    chk("R5 carry with enP low", int'(carryOut), 1);
    step();
    chk("R4 hold enP low", int'(countQ), FULL - 1);
    cntEnP = 1'b1; cntEnT = 1'b0;
    #0.5;
    chk("R5 carry with enT low", int'(carryOut), 0);
    step();
    chk("R4 hold enT low", int'(countQ), FULL - 1);
    cntEnP = 1'b0;
    step();
    chk("R4 hold both low", int'(countQ), FULL - 1);

    // R6: glitches between edges do not disturb the count
    loadVal = W'(5);
    loadN = 1'b0;
    #1;
    chk("R6 load glitch mid-cycle", int'(countQ), FULL - 1);
    loadN = 1'b1; cntEnP = 1'b1; cntEnT = 1'b1;
    #0.5;
    chk("R6 enable glitch mid-cycle", int'(countQ), FULL - 1);
    cntEnP = 1'b0; cntEnT = 1'b0;
    step();
    chk("R6 after edge", int'(countQ), FULL - 1);

    // R1: clear while counting, between edges
    loadVal = W'(100); loadN = 1'b0;
    step();
    loadN = 1'b1; cntEnP = 1'b1; cntEnT = 1'b1;
    step();
    chk("R3 count from 100", int'(countQ), 101);
    clearN = 1'b0;
    #0.5;
    chk("R1 async clear", int'(countQ), 0);
    step();
    chk("R1 clear beats count", int'(countQ), 0);
    clearN = 1'b1;

    // R9: cut stage 1 carry-chain enable
    mD[0] = 4'd0; mD[1] = 4'd15; mD[2] = 4'd3;
    mLoadN = 1'b0;
    step();
    mLoadN = 1'b1; mMask = 3'b101; mEnP = 1'b1; mEnT = 1'b1;
    for (int n = 1; n <= 40; n++) begin
      step();
      chk("R9 low stage counts", int'(mQ[0]), n % 16);
      chk("R9 cut stage frozen", int'(mQ[1]), 15);
      chk("R9 upper stage frozen", int'(mQ[2]), 3);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule